// File: doc/BRIEF.md
# Two-Output Level Interrupt Router

This block collects level-sensitive interrupt request lines from peripherals and steers them onto two CPU interrupt lines. Each request passes through a two-flop synchronizer into a raw pending word. A per-source mask decides whether a pending source counts. A per-source route bit decides which of the two outputs it drives. A single global gate bit must be set before either output can assert.

Software changes the mask only through two write ports. One port sets mask bits wherever a 1 is written, and the other clears them wherever a 1 is written. A read-modify-write is therefore never needed. The gate shares the top bit of both ports with the mask. Pending bits are not latched, so software clears a request at the peripheral that raised it. The bus is a plain single-cycle register access: writes take effect on the clock edge where the select and write strobes are high, and read data is combinational from the address.

Top module: `irq_router`

## Requirements
- R1: After reset the mask, the gate and every route bit are 0, both interrupt outputs are low, and reads of the mask (0x34) and route (0x20) registers return 0.
- R2: A write to 0x34 sets each mask bit written as 1, and bit 31 of the word sets the gate. Bits written as 0 leave their mask bit unchanged.
- R3: A write to 0x38 clears each mask bit written as 1, and bit 31 of the word clears the gate. Bits written as 0 are unchanged. Writing all ones clears every mask bit and the gate.
- R4: The route register at 0x20 is read/write, one bit per source. Route bit 0 steers the source to output 0, and route bit 1 steers it to output 1.
- R5: While the gate is 0, neither output asserts, whatever the pending and mask state.
- R6: The raw word at 0x30 shows each request line two clock edges after it changes. It follows the line in both directions and holds no memory of past requests.
- R7: Reading 0x00 returns raw & mask & ~route, and reading 0x04 returns raw & mask & route. Neither word depends on the gate.
- R8: Output n is a register. It is high on the edge after its status word is nonzero while the gate is set, and low on the edge after either condition fails.
- R9: Reading the mask register returns the mask with the gate in bit 31. Reads of 0x38 and of any unmapped address return 0.
- R10: Writes to the status, raw or unmapped addresses change neither the mask, the gate nor the route bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 31 | Level interrupt requests, one per source |
| sel_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Register byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| irq0_o | output | 1 | CPU interrupt line 0 |
| irq1_o | output | 1 | CPU interrupt line 1 |

## Verification
A request change reaches the raw and status words after two edges and reaches an output after three. A register write changes the status words on its own edge and the outputs one edge later. The bench drives every stimulus on a falling edge and counts whole cycles before each sample. It also samples one cycle early to show that a result has not yet arrived, for example an output that is still low right after the write that opens the gate. Reads are sampled shortly after the address settles, with no rising edge between the drive and the sample.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int ADDR_W = 6;

  typedef enum logic [ADDR_W-1:0] {
    A_ST0  = 6'h00,
    A_ST1  = 6'h04,
    A_TYPE = 6'h20,
    A_RAW  = 6'h30,
    A_EN   = 6'h34,
    A_DIS  = 6'h38
  } reg_addr_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 31,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) q[s] <= '0;
    end else begin
      q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) q[s] <= q[s-1];
    end
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_router_pkg::*;
#(
  parameter int N_SRC = 31,
  parameter int DW    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [N_SRC-1:0]  en_o,
  output logic              gate_o,
  output logic [N_SRC-1:0]  type_o
);
  localparam int GATE = DW - 1;

  logic [N_SRC-1:0] en_q, type_q;
  logic             gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      type_q <= '0;
      gate_q <= 1'b0;
    end else if (wr_i) begin
      case (addr_i)
        A_EN: begin
          en_q   <= en_q | wdata_i[N_SRC-1:0];
          gate_q <= gate_q | wdata_i[GATE];
        end
        A_DIS: begin
          en_q   <= en_q & ~wdata_i[N_SRC-1:0];
          gate_q <= gate_q & ~wdata_i[GATE];
        end
        A_TYPE: type_q <= wdata_i[N_SRC-1:0];
        default: ;
      endcase
    end
  end

  assign en_o   = en_q;
  assign gate_o = gate_q;
  assign type_o = type_q;

  assert_set_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_EN) |=>
      ((en_q & $past(wdata_i[N_SRC-1:0])) == $past(wdata_i[N_SRC-1:0]))
      && (gate_q || !$past(wdata_i[GATE])));

  assert_clr_en_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_DIS) |=>
      ((en_q & $past(wdata_i[N_SRC-1:0])) == '0)
      && !(gate_q && $past(wdata_i[GATE])));

  assert_type_wr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_TYPE) |=> type_q == $past(wdata_i[N_SRC-1:0]));

  assert_ro_keep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && (addr_i == A_EN || addr_i == A_DIS || addr_i == A_TYPE)) |=>
      $stable(en_q) && $stable(gate_q) && $stable(type_q));
endmodule

// File: rtl/irq_out.sv
module irq_out #(
  parameter int N_SRC = 31,
  parameter int N_OUT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] raw_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] type_i,
  input  logic             gate_i,
  output logic [N_SRC-1:0] st_o [N_OUT],
  output logic [N_OUT-1:0] irq_o
);
  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    logic [N_SRC-1:0] route;
    logic             irq_q;

    // route bit selects output 1 when set, output 0 when clear
    assign route   = (g == 0) ? ~type_i : type_i;
    assign st_o[g] = raw_i & en_i & route;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q <= 1'b0;
      else         irq_q <= gate_i && (|st_o[g]);
    end
    assign irq_o[g] = irq_q;

    assert_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(gate_i) |-> !irq_q);

    assert_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_q |-> $past(|(raw_i & en_i & ((g == 0) ? ~type_i : type_i))));
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int N_SRC = 31,
  parameter int DW    = 32,
  parameter int SYNC  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  req_i,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              irq0_o,
  output logic              irq1_o
);
  localparam int GATE = DW - 1;

  logic [N_SRC-1:0] raw, en, typ;
  logic [N_SRC-1:0] st [2];
  logic             gate;
  logic [1:0]       irq;

  irq_sync #(.W(N_SRC), .STAGES(SYNC)) i_sync (
    .clk_i, .rst_ni, .d_i(req_i), .q_o(raw)
  );

  irq_regs #(.N_SRC(N_SRC), .DW(DW)) i_regs (
    .clk_i, .rst_ni,
    .wr_i   (sel_i && we_i),
    .addr_i,
    .wdata_i,
    .en_o   (en),
    .gate_o (gate),
    .type_o (typ)
  );

  irq_out #(.N_SRC(N_SRC), .N_OUT(2)) i_out (
    .clk_i, .rst_ni,
    .raw_i (raw),
    .en_i  (en),
    .type_i(typ),
    .gate_i(gate),
    .st_o  (st),
    .irq_o (irq)
  );

  assign irq0_o = irq[0];
  assign irq1_o = irq[1];

  always_comb begin
    rdata_o = '0;
    if (sel_i && !we_i) begin
      case (addr_i)
        A_ST0:  rdata_o[N_SRC-1:0] = st[0];
        A_ST1:  rdata_o[N_SRC-1:0] = st[1];
        A_TYPE: rdata_o[N_SRC-1:0] = typ;
        A_RAW:  rdata_o[N_SRC-1:0] = raw;
        A_EN: begin
          rdata_o[N_SRC-1:0] = en;
          rdata_o[GATE]      = gate;
        end
        default: ;
      endcase
    end
  end

  assert_out_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq0_o || irq1_o) |-> $past(gate));

  assert_disjoint_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st[0] & st[1]) == '0);
endmodule

// File: tb/test_irq_router.sv
`timescale 1ns/1ps
module test_irq_router;
  localparam logic [5:0] ST0 = 6'h00, ST1 = 6'h04, TYP = 6'h20,
                         RAW = 6'h30, EN = 6'h34, DIS = 6'h38;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [30:0] req = '0;
  logic        sel = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq0, irq1;
  int          n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  irq_router i_irq_router (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .sel_i(sel), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq0_o(irq0), .irq1_o(irq1)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    sel = 1'b1; we = 1'b0; addr = a;
    #0.5 d = rdata;
    sel = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 irq0", {31'd0, irq0}, 32'd0);
    chk("R1 irq1", {31'd0, irq1}, 32'd0);
    rd(EN, v);  chk("R1 enable", v, 32'd0);
    rd(TYP, v); chk("R1 type", v, 32'd0);
  endtask

  task automatic t_set_clear;
    logic [31:0] v;
    wr(EN, 32'h5);
    wr(EN, 32'h2);
    rd(EN, v); chk("R2 set accumulates", v, 32'h7);
    wr(DIS, 32'h4);
    rd(EN, v); chk("R3 clear one bit", v, 32'h3);
    rd(DIS, v); chk("R9 disable reads zero", v, 32'h0);
    wr(EN, 32'h8000_0000);
    rd(EN, v); chk("R9 enable shows gate", v, 32'h8000_0003);
    wr(DIS, 32'hFFFF_FFFF);
    rd(EN, v); chk("R3 clear all", v, 32'h0);
  endtask

  task automatic t_gate;
    logic [31:0] v;
    req = 31'h1;
    wr(EN, 32'h1);
    tick(3);
    chk("R5 gate closed", {31'd0, irq0}, 32'd0);
    rd(ST0, v); chk("R7 status0 ignores gate", v, 32'h1);
    wr(EN, 32'h8000_0000);
    chk("R8 not yet high", {31'd0, irq0}, 32'd0);
    tick(1);
    chk("R8 irq0 high", {31'd0, irq0}, 32'd1);
    chk("R8 irq1 low", {31'd0, irq1}, 32'd0);
  endtask

  task automatic t_route;
    logic [31:0] v;
    wr(TYP, 32'h1);
    rd(TYP, v); chk("R4 type readback", v, 32'h1);
    rd(ST1, v); chk("R7 status1", v, 32'h1);
    rd(ST0, v); chk("R7 status0 empty", v, 32'h0);
    tick(1);
    chk("R4 irq0 off", {31'd0, irq0}, 32'd0);
    chk("R4 irq1 on", {31'd0, irq1}, 32'd1);
    wr(TYP, 32'h0);
    tick(1);
    chk("R4 back to irq0", {irq1, irq0}, 32'd1);
  endtask

  task automatic t_level;
    logic [31:0] v;
    @(negedge clk); req = 31'h6;
    tick(1);
    rd(RAW, v); chk("R6 raw one edge", v, 32'h1);
    tick(1);
    rd(RAW, v); chk("R6 raw two edges", v, 32'h6);
    rd(ST0, v); chk("R7 masked sources", v, 32'h0);
    chk("R8 irq0 still high", {31'd0, irq0}, 32'd1);
    tick(1);
    chk("R8 irq0 drops", {31'd0, irq0}, 32'd0);
    req = 31'h4000_0000;
    wr(EN, 32'h4000_0000);
    wr(TYP, 32'h4000_0000);
    rd(ST1, v); chk("R7 top source to 1", v, 32'h4000_0000);
    tick(1);
    chk("R8 irq1 top source", {irq1, irq0}, 32'd2);
    req = '0;
    tick(2);
    rd(RAW, v); chk("R6 not latched", v, 32'h0);
    tick(1);
    chk("R6 irq1 follows level", {31'd0, irq1}, 32'd0);
  endtask

  task automatic t_ignored;
    logic [31:0] v;
    wr(ST0, 32'hFFFF_FFFF);
    wr(ST1, 32'hFFFF_FFFF);
    wr(RAW, 32'hFFFF_FFFF);
    wr(6'h10, 32'hFFFF_FFFF);
    rd(EN, v);  chk("R10 enable kept", v, 32'hC000_0001);
    rd(TYP, v); chk("R10 type kept", v, 32'h4000_0000);
    rd(6'h10, v); chk("R9 unmapped zero", v, 32'h0);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_set_clear();
    t_gate();
    t_route();
    t_level();
    t_ignored();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule